// File: doc/BRIEF.md
# Hoppable NCO Phase Generator

This block produces the phase word for one receive channel's numerically controlled oscillator. Software writes a 32-bit tuning word as two 16-bit halves. The halves land in shadow storage and do not disturb the running oscillator. The shadow word becomes the active increment on one of two events: a hop strobe, raised when a sync-driven hold-off count completes, or the channel leaving sleep. The accumulator adds the active increment once for each qualified input sample. A 16-bit phase offset is added to the top half of the accumulator, and the result goes out as a registered 16-bit phase for a downstream sine/cosine lookup.

A control register sets three things: whether a hop keeps the accumulator (phase continuous) or clears it, how the input-enable level qualifies samples, and the dither enables and bypass flag. The block forwards the bypass flag and the amplitude-dither flag to the mixer and lookup stages. It applies phase dither itself by adding a pseudo-random value below the output bits.

Register select `wr_sel_i` addresses four registers: 0 is the low tuning half, 1 is the high tuning half, 2 is the phase offset, and 3 is control. The control fields are bit 0 bypass, bit 1 phase dither, bit 2 amplitude dither, bit 3 clear-on-hop, and bits 5:4 enable mode.

Top module: `nco_hop_top`

## Requirements
- R1: After reset, the accumulator, active word, shadow word, offset and control are zero, and phase_o, bypass_o and amp_dither_o are 0.
- R2: Writes to select 0 (bits 15:0) and select 1 (bits 31:16) change only the shadow word. The phase progression is unaffected until a commit.
- R3: A hop_i pulse while awake copies the shadow word into the active word. With control bit 3 clear, the accumulator value is kept, and the sample in the hop cycle (if any) already adds the new word.
- R4: With control bit 3 set, a hop sets the accumulator to 0 plus the new word if a qualified sample arrives in that cycle, and to 0 otherwise.
- R5: While sleep_i is high, the accumulator does not advance and hop_i is ignored. The cycle in which sleep_i falls commits the shadow word to the active word.
- R6: Each qualified sample adds the active word to the accumulator modulo 2^32. A sample is qualified only when smp_valid_i is high and sleep_i is low.
- R7: With phase dither off, phase_o equals (accumulator[31:16] + offset) mod 2^16, taken from the values of the previous cycle.
- R8: Enable mode 00 (control bits 5:4) qualifies every valid sample regardless of smp_en_i.
- R9: Enable mode 01 qualifies a valid sample only while smp_en_i is high.
- R10: Enable mode 10 qualifies a valid sample only when smp_en_i is high and it was low in the previous clock cycle.
- R11: Enable mode 11 qualifies a valid sample only when smp_en_i is low and it was high in the previous clock cycle.
- R12: With control bit 1 set, a pseudo-random value below bit 16 is added before truncation, so phase_o is the undithered value or that value plus 1 (mod 2^16).
- R13: bypass_o follows control bit 0 and amp_dither_o follows control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Channel sleep level |
| hop_i | input | 1 | Hop strobe from sync hold-off logic |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 16 | Register write data |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_en_i | input | 1 | Input enable level |
| phase_o | output | 16 | Registered output phase |
| bypass_o | output | 1 | Bypass flag for the mixer |
| amp_dither_o | output | 1 | Amplitude dither flag for the lookup |

## Verification
The bench sweeps all four enable modes against every combination of the previous and current enable level. An edge mode keyed to the wrong level or to the wrong side of the register would step the accumulator on the wrong samples. It drives tuning words that wrap the 32-bit accumulator, and offsets that wrap the 16-bit sum. Dropping the carry would show up there as phase jumps. It checks that shadow writes stay invisible until a hop or a sleep exit, that a hop during sleep is ignored, and that the clear-on-hop bit both resets the phase and leaves continuity intact when clear. With dither on, it confirms that the output never departs from the undithered phase by more than one step.

// File: rtl/nco_hop_pkg.sv
`timescale 1ns/1ps
package nco_hop_pkg;
  typedef enum logic [1:0] {
    SEL_FRQ_LO = 2'd0,
    SEL_FRQ_HI = 2'd1,
    SEL_POFS   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    EN_ALWAYS = 2'd0,
    EN_LEVEL  = 2'd1,
    EN_RISE   = 2'd2,
    EN_FALL   = 2'd3
  } en_mode_e;

  // bit 5:4 mode, 3 clear-on-hop, 2 amp dither, 1 phase dither, 0 bypass
  typedef struct packed {
    en_mode_e en_mode;
    logic     clr_on_hop;
    logic     amp_dith;
    logic     ph_dith;
    logic     bypass;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/nco_hop_regs.sv
`timescale 1ns/1ps
module nco_hop_regs
  import nco_hop_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int PHASE_W = 16,
  localparam int FW     = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [FW-1:0]     shadow_o,
  output logic [PHASE_W-1:0] pofs_o,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      pofs_o   <= '0;
      ctrl_o   <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_FRQ_LO: shadow_o[HALF_W-1:0]  <= wr_data_i;
        SEL_FRQ_HI: shadow_o[FW-1:HALF_W] <= wr_data_i;
        SEL_POFS:   pofs_o                <= wr_data_i[PHASE_W-1:0];
        default:    ctrl_o                <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/nco_hop_qual.sv
`timescale 1ns/1ps
module nco_hop_qual
  import nco_hop_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  en_mode_e mode_i,
  input  logic     valid_i,
  input  logic     en_i,
  input  logic     sleep_i,
  output logic     qual_o
);
  logic en_q;
  logic pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  always_comb begin
    unique case (mode_i)
      EN_ALWAYS: pass = 1'b1;
      EN_LEVEL:  pass = en_i;
      EN_RISE:   pass = en_i & ~en_q;
      default:   pass = ~en_i & en_q;
    endcase
  end

  assign qual_o = valid_i & ~sleep_i & pass;
endmodule

// File: rtl/nco_hop_accum.sv
`timescale 1ns/1ps
module nco_hop_accum #(
  parameter int FW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          qual_i,
  input  logic          hop_i,
  input  logic          sleep_i,
  input  logic          clr_on_hop_i,
  input  logic [FW-1:0] shadow_i,
  output logic [FW-1:0] acc_o,
  output logic [FW-1:0] active_o,
  output logic          commit_o
);
  logic          sleep_q;
  logic          hop_ok;
  logic [FW-1:0] base;
  logic [FW-1:0] inc;

  assign hop_ok   = hop_i & ~sleep_i;
  assign commit_o = hop_ok | (sleep_q & ~sleep_i);
  assign base     = (hop_ok && clr_on_hop_i) ? '0 : acc_o;
  assign inc      = commit_o ? shadow_i : active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q  <= 1'b0;
      acc_o    <= '0;
      active_o <= '0;
    end else begin
      sleep_q <= sleep_i;
      acc_o   <= base + (qual_i ? inc : '0);
      if (commit_o) active_o <= shadow_i;
    end
  end
endmodule

// File: rtl/nco_hop_phase.sv
`timescale 1ns/1ps
module nco_hop_phase #(
  parameter int FW     = 32,
  parameter int OW     = 16,
  parameter int LFSR_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] acc_i,
  input  logic [OW-1:0] pofs_i,
  input  logic          dith_i,
  output logic [OW-1:0] phase_o
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(16'hACE1);
  localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(16'hB400);

  logic [LFSR_W-1:0] lfsr_q;
  logic [FW-1:0]     acc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
  end

  // dither stays below the output bits
  assign acc_d = acc_i + {{(FW-LFSR_W){1'b0}}, lfsr_q & {LFSR_W{dith_i}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= acc_d[FW-1 -: OW] + pofs_i;
  end
endmodule

// File: rtl/nco_hop_top.sv
`timescale 1ns/1ps
module nco_hop_top
  import nco_hop_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  localparam int HALF_W = FREQ_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic               hop_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [HALF_W-1:0]  wr_data_i,
  input  logic               smp_valid_i,
  input  logic               smp_en_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               bypass_o,
  output logic               amp_dither_o
);
  logic [FREQ_W-1:0]  shadow;
  logic [FREQ_W-1:0]  active;
  logic [FREQ_W-1:0]  acc;
  logic [PHASE_W-1:0] pofs;
  ctrl_t              ctrl;
  logic               qual;
  logic               commit;

  nco_hop_regs #(.HALF_W(HALF_W), .PHASE_W(PHASE_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .shadow_o(shadow), .pofs_o(pofs), .ctrl_o(ctrl)
  );

  nco_hop_qual qual_i (
    .clk_i, .rst_ni, .mode_i(ctrl.en_mode), .valid_i(smp_valid_i),
    .en_i(smp_en_i), .sleep_i, .qual_o(qual)
  );

  nco_hop_accum #(.FW(FREQ_W)) accum_i (
    .clk_i, .rst_ni, .qual_i(qual), .hop_i, .sleep_i,
    .clr_on_hop_i(ctrl.clr_on_hop), .shadow_i(shadow),
    .acc_o(acc), .active_o(active), .commit_o(commit)
  );

  nco_hop_phase #(.FW(FREQ_W), .OW(PHASE_W)) phase_i (
    .clk_i, .rst_ni, .acc_i(acc), .pofs_i(pofs),
    .dith_i(ctrl.ph_dith), .phase_o
  );

  assign bypass_o     = ctrl.bypass;
  assign amp_dither_o = ctrl.amp_dith;
endmodule

// File: rtl/nco_hop_chk.sv
`timescale 1ns/1ps
module nco_hop_chk #(
  parameter int FW = 32,
  parameter int PW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          hop_i,
  input logic          smp_valid_i,
  input logic          qual,
  input logic          commit,
  input logic          clr,
  input logic          ph_dith,
  input logic [FW-1:0] shadow,
  input logic [FW-1:0] active,
  input logic [FW-1:0] acc,
  input logic [PW-1:0] pofs,
  input logic [PW-1:0] phase_o
);
  p_qual_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |-> (smp_valid_i && !sleep_i));

  p_acc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!qual && !commit) |=> $stable(acc));

  p_commit_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (active == $past(shadow)));

  p_shadow_hidden_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(active));

  p_hop_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hop_i && !sleep_i && clr && !qual) |=> (acc == '0));

  p_sleep_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(acc));

  p_phase_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_dith |=> (phase_o == $past(acc[FW-1 -: PW] + pofs)));
endmodule

bind nco_hop_top nco_hop_chk #(.FW(FREQ_W), .PW(PHASE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .hop_i(hop_i),
  .smp_valid_i(smp_valid_i), .qual(qual), .commit(commit),
  .clr(ctrl.clr_on_hop), .ph_dith(ctrl.ph_dith), .shadow(shadow),
  .active(active), .acc(acc), .pofs(pofs), .phase_o(phase_o)
);

// File: tb/nco_hop_top_tb_top.sv
`timescale 1ns/1ps
module nco_hop_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0, hop = 1'b0, wr_en = 1'b0, valid = 1'b0, en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] phase;
  logic        byp, ampd;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_acc = '0, m_act = '0, m_shd = '0;
  logic [15:0] m_ofs = '0;
  logic [1:0]  m_mode = '0;
  logic        m_clr = 1'b0;
  logic        m_en_prev = 1'b0;

  always #5 clk = ~clk;

  nco_hop_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .hop_i(hop),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .smp_valid_i(valid), .smp_en_i(en), .phase_o(phase),
    .bypass_o(byp), .amp_dither_o(ampd)
  );

  task automatic tick();
    @(posedge clk);
    m_en_prev = en;
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
    case (sel)
      2'd0: m_shd[15:0]  = d;
      2'd1: m_shd[31:16] = d;
      2'd2: m_ofs        = d;
      default: begin m_mode = d[5:4]; m_clr = d[3]; end
    endcase
  endtask

  task automatic set_shadow(logic [31:0] w);
    wr(2'd0, w[15:0]);
    wr(2'd1, w[31:16]);
  endtask

  function automatic logic passes(logic [1:0] md, logic p, logic c);
    case (md)
      2'd0: return 1'b1;
      2'd1: return c;
      2'd2: return c & ~p;
      default: return ~c & p;
    endcase
  endfunction

  task automatic smp(logic e);
    logic q;
    q = passes(m_mode, m_en_prev, e) & ~sleep;
    valid = 1'b1; en = e;
    tick();
    valid = 1'b0;
    if (q) m_acc = m_acc + m_act;
  endtask

  task automatic do_hop(logic with_smp);
    hop = 1'b1;
    if (with_smp) valid = 1'b1;
    tick();
    hop = 1'b0; valid = 1'b0;
    if (!sleep) begin
      m_act = m_shd;
      if (m_clr) m_acc = '0;
      if (with_smp && passes(m_mode, 1'b0, en)) m_acc = m_acc + m_act;
    end
  endtask

  task automatic chk_phase(string req);
    tick();
    chk(req, {16'h0, phase}, {16'h0, m_acc[31:16] + m_ofs});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phase", {16'h0, phase}, 32'h0);
    chk("R1 bypass", {31'h0, byp}, 32'h0);
    chk("R1 amp", {31'h0, ampd}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 phase after release", {16'h0, phase}, 32'h0);

    // R2: shadow writes stay hidden
    set_shadow(32'h0123_4567);
    for (int i = 0; i < 3; i++) begin smp(1'b1); chk_phase("R2 hidden"); end

    // R3/R6: hop commits, then accumulate
    do_hop(1'b0);
    for (int i = 0; i < 6; i++) begin smp(1'b1); chk_phase("R6 accumulate"); end

    // R6: modulo wrap
    set_shadow(32'hF000_0001);
    do_hop(1'b0);
    for (int i = 0; i < 20; i++) begin smp(1'b0); chk_phase("R6 wrap"); end

    // R7: offset sweep with wrap of the 16-bit sum
    foreach (m_ofs[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [15:0] o;
      o = (k == 0) ? 16'h0000 : (k == 1) ? 16'h8000 : (k == 2) ? 16'hFFFF :
          (k == 3) ? 16'h1234 : (k == 4) ? 16'hEDCB : 16'h7FFF;
      wr(2'd2, o);
      chk_phase("R7 offset");
      smp(1'b1);
      chk_phase("R7 offset step");
    end
    wr(2'd2, 16'h0);

    // R3: continuous hop keeps accumulator, sample in hop cycle uses new word
    set_shadow(32'h0010_0000);
    chk_phase("R2 hidden before hop");
    do_hop(1'b0);
    chk_phase("R3 continuity");
    set_shadow(32'h0300_0000);
    en = 1'b1;
    do_hop(1'b1);
    chk_phase("R3 hop with sample");
    smp(1'b1); chk_phase("R3 new word");

    // R4: clear on hop
    wr(2'd3, 16'h0008);
    wr(2'd2, 16'h0042);
    set_shadow(32'h0055_0000);
    do_hop(1'b0);
    chk_phase("R4 cleared");
    smp(1'b1); chk_phase("R4 after clear");
    smp(1'b1);
    do_hop(1'b1);
    chk_phase("R4 clear with sample");
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'h0000);

    // R5: sleep holds, hop ignored, exit commits
    sleep = 1'b1;
    tick();
    set_shadow(32'h0A00_0000);
    for (int i = 0; i < 3; i++) begin smp(1'b1); chk_phase("R5 sleep hold"); end
    do_hop(1'b0);
    chk_phase("R5 hop ignored");
    sleep = 1'b0;
    tick();
    m_act = m_shd;
    smp(1'b1); chk_phase("R5 exit commit");

    // R8-R11: enable modes against every prev/current level
    set_shadow(32'h0001_0000);
    do_hop(1'b0);
    for (int md = 0; md < 4; md++) begin
      wr(2'd3, 16'(md << 4));
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 2; c++) begin
          en = p[0];
          tick();
          smp(c[0]);
          case (md)
            0: chk_phase("R8 mode always");
            1: chk_phase("R9 mode level");
            2: chk_phase("R10 mode rise");
            default: chk_phase("R11 mode fall");
          endcase
        end
      end
    end

    // R13: flag outputs
    wr(2'd3, 16'h0001);
    chk("R13 bypass", {30'h0, ampd, byp}, 32'h1);
    wr(2'd3, 16'h0004);
    chk("R13 amp dither", {30'h0, ampd, byp}, 32'h2);

    // R12: phase dither bounded to +1
    set_shadow(32'h0123_F00F);
    do_hop(1'b0);
    wr(2'd2, 16'h3000);
    wr(2'd3, 16'h0002);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] d;
      smp(1'b1);
      tick();
      d = phase - (m_acc[31:16] + m_ofs);
      checks++;
      if (d > 16'd1) begin
        errors++;
        $display("FAIL R12 dither: actual=%h expected=%h or +1", phase, m_acc[31:16] + m_ofs);
      end
    end
    wr(2'd3, 16'h0000);
    chk_phase("R12 dither off exact");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule